// File: doc/BRIEF.md
# Bus-Mastering Block Transfer Engine

This block copies a run of words between a streaming device port and system memory on its own, so the processor does not have to move each word. Software loads a start address and a word count into two registers. It then writes the control register with the start bit set, together with a pacing choice and a direction. The engine asks for the shared bus with a request line and waits for the grant line. While it holds the grant it drives the address, the write data and the strobes for one memory cycle per word. It lets go of the bus when it is finished. Completion is reported through a sticky done flag that also drives the interrupt line.

Two pacing choices exist. In continuous pacing the engine holds a single bus tenure and moves the whole block inside it. In stealing pacing it takes exactly one word per tenure. After each word it gives the bus back and waits for the processor's end-of-instruction pulse before it asks again. The first word also waits for such a pulse. Either way, the done flag is set only after the engine has dropped its request and the grant has gone low.

Top module: `dma_ctrl`

## Requirements
- R1: The register port uses four word offsets. Offset 0 is the memory address and offset 1 is the word count; both read back their live values. Offset 2 is control: bit 0 is start, which is write-only and reads 0; bit 1 selects pacing (1 = stealing, 0 = continuous); bit 2 selects direction (1 = memory to device, 0 = device to memory). Offset 3 is status: bit 0 is busy, bit 1 is done. All of these read 0 after reset.
- R2: A start with a nonzero count raises `br`. `bus_oe`, `mem_we` and `mem_re` are only ever high while `bg` is high.
- R3: Each memory cycle completes when the strobe and `mem_ack` are high in the same cycle. Each such completion moves the address up by one and the count down by one, so successive cycles use consecutive addresses starting at the programmed one. Read-back after the block ends shows start+count and 0.
- R4: In device-to-memory direction the device words are written to memory in arrival order, with `mem_wdata` equal to `dev_in_data` and `dev_in_ready` pulsing on completion. In memory-to-device direction each word read is presented on `dev_out_data`/`dev_out_valid` in address order, and the next read waits until the device has taken the word.
- R5: In continuous pacing the whole block moves inside one grant tenure.
- R6: In stealing pacing each grant tenure carries exactly one word. Every request, the first included, follows an `end_of_instr` pulse seen while the engine was waiting.
- R7: Done (and `irq`) is set when the count is zero, `br` is low and `bg` has gone low. Busy clears on the same edge.
- R8: Writing status with bit 1 set clears done and `irq`. If completion falls in the same cycle as that write, done stays set.
- R9: A start with a count of zero sets done on the next edge and never raises `br`.
- R10: While busy, writes to address, count and control are ignored, including a second start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register word offset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| irq | output | 1 | Interrupt request, equal to the done flag |
| br | output | 1 | Bus request |
| bg | input | 1 | Bus grant |
| end_of_instr | input | 1 | One-cycle pulse at the end of each processor instruction |
| bus_oe | output | 1 | Engine is driving the bus |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | DW | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory cycle completes |
| dev_in_valid | input | 1 | Device has a word for memory |
| dev_in_ready | output | 1 | Device word taken |
| dev_in_data | input | DW | Device word for memory |
| dev_out_valid | output | 1 | Word for the device is present |
| dev_out_ready | input | 1 | Device takes the word |
| dev_out_data | output | DW | Word read from memory |

## Verification
Two things can land on the same clock edge: the engine finishing a block (grant seen low with the count at zero) and software writing the done-clear bit. The bench provokes this by leaving done set from an earlier run. It then holds the grant high after the request drops, and in one cycle lowers the grant and issues the status clear. The result passes only if done and `irq` are still high after that edge, and a separate clear afterwards brings them low. A reference model in the bench follows every clock to check each memory cycle's address and data, how many words each tenure carries, and when the interrupt rises relative to the grant.

// File: rtl/dma_pkg.sv
// Package dma_pkg: shared state encoding, register offsets and bit positions
// for the block transfer engine. Assumes a four-word register window.
package dma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_EOI,
        ST_REQ,
        ST_XFER,
        ST_RELEASE
    } dma_state_t;

    localparam logic [1:0] OFS_ADDR  = 2'd0;
    localparam logic [1:0] OFS_COUNT = 2'd1;
    localparam logic [1:0] OFS_CTRL  = 2'd2;
    localparam logic [1:0] OFS_STAT  = 2'd3;

    localparam int CTRL_START = 0;
    localparam int CTRL_STEAL = 1;
    localparam int CTRL_DIR   = 2;
    localparam int STAT_BUSY  = 0;
    localparam int STAT_DONE  = 1;
endpackage

// File: rtl/dma_regs.sv
// Module dma_regs: software register window. It holds the pacing and
// direction bits and the sticky done flag, decodes writes into load and start
// pulses, and muxes the read data. Assumes the address and count storage live
// in the sequencer and are only loaded while the engine is idle.
module dma_regs
    import dma_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    reg_addr,
    input  logic          reg_wr_en,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          busy,
    input  logic          finish,
    input  logic [AW-1:0] cur_addr,
    input  logic [CW-1:0] cur_count,
    output logic          ld_addr,
    output logic          ld_count,
    output logic          start,
    output logic          start_steal,
    output logic          steal_q,
    output logic          dir_rd_q,
    output logic          done
);
    logic wr_ctrl;
    logic wr_stat;
    logic unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[DW-1:3];

    // Decode software writes; configuration writes are dropped while busy.
    always_comb begin
        ld_addr     = reg_wr_en && (reg_addr == OFS_ADDR) && !busy;
        ld_count    = reg_wr_en && (reg_addr == OFS_COUNT) && !busy;
        wr_ctrl     = reg_wr_en && (reg_addr == OFS_CTRL) && !busy;
        wr_stat     = reg_wr_en && (reg_addr == OFS_STAT);
        start       = wr_ctrl && reg_wdata[CTRL_START];
        start_steal = reg_wdata[CTRL_STEAL];
    end

    // Hold pacing and direction chosen by the last accepted control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            steal_q  <= 1'b0;
            dir_rd_q <= 1'b0;
        end else if (wr_ctrl) begin
            steal_q  <= reg_wdata[CTRL_STEAL];
            dir_rd_q <= reg_wdata[CTRL_DIR];
        end
    end

    // Sticky done flag: completion outranks a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else if (finish) begin
            done <= 1'b1;
        end else if (wr_stat && reg_wdata[STAT_DONE]) begin
            done <= 1'b0;
        end
    end

    // Read mux over the four-word window.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_ADDR:  reg_rdata = DW'(cur_addr);
            OFS_COUNT: reg_rdata = DW'(cur_count);
            OFS_CTRL: begin
                reg_rdata[CTRL_STEAL] = steal_q;
                reg_rdata[CTRL_DIR]   = dir_rd_q;
            end
            default: begin
                reg_rdata[STAT_BUSY] = busy;
                reg_rdata[STAT_DONE] = done;
            end
        endcase
    end

    // R10: configuration cannot change under a running block.
    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(steal_q) && $stable(dir_rd_q)));
endmodule

// File: rtl/dma_addr_cnt.sv
// Module dma_addr_cnt: address and remaining-count storage. It loads from
// software and steps once per completed memory cycle. Assumes load and step
// never coincide (loads are only accepted while idle).
module dma_addr_cnt #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_addr,
    input  logic          ld_count,
    input  logic [AW-1:0] new_addr,
    input  logic [CW-1:0] new_count,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic [CW-1:0] count,
    output logic          cnt_zero,
    output logic          cnt_one
);
    localparam logic [AW-1:0] ADDR_INC = AW'(1);
    localparam logic [CW-1:0] CNT_DEC  = CW'(1);

    // Address register: load from software or advance one word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (ld_addr) begin
            addr <= new_addr;
        end else if (step) begin
            addr <= addr + ADDR_INC;
        end
    end

    // Remaining-count register: load from software or count one word down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (ld_count) begin
            count <= new_count;
        end else if (step) begin
            count <= count - CNT_DEC;
        end
    end

    // Flags that the sequencer uses to end a block.
    always_comb begin
        cnt_zero = (count == '0);
        cnt_one  = (count == CNT_DEC);
    end

    // R3: the sequencer never steps an exhausted count.
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !cnt_zero);
endmodule

// File: rtl/dma_bus_fsm.sv
// Module dma_bus_fsm: bus ownership and transfer sequencer. It runs the
// request/grant handshake, issues one memory strobe per word, moves data
// between device port and memory, and signals completion once the grant
// is gone. Assumes the grant is not withdrawn while the request is high
// and that dev_in_data is held stable while dev_in_valid is high.
module dma_bus_fsm
    import dma_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_steal,
    input  logic          steal,
    input  logic          dir_rd,
    input  logic          cnt_zero,
    input  logic          cnt_one,
    input  logic          bg,
    input  logic          end_of_instr,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    input  logic          dev_in_valid,
    input  logic [DW-1:0] dev_in_data,
    input  logic          dev_out_ready,
    output logic          br,
    output logic          bus_oe,
    output logic          mem_we,
    output logic          mem_re,
    output logic [DW-1:0] mem_wdata,
    output logic          dev_in_ready,
    output logic          dev_out_valid,
    output logic [DW-1:0] dev_out_data,
    output logic          step,
    output logic          finish,
    output logic          busy
);
    dma_state_t state, state_nx;
    logic       out_full;
    logic       owning;

    // Strobes and data steering while the engine owns the bus.
    always_comb begin
        owning       = (state == ST_XFER) && bg;
        bus_oe       = owning;
        mem_we       = owning && !dir_rd && dev_in_valid;
        mem_re       = owning && dir_rd && !out_full;
        mem_wdata    = dir_rd ? '0 : dev_in_data;
        step         = (mem_we || mem_re) && mem_ack;
        dev_in_ready = mem_we && mem_ack;
        br           = (state == ST_REQ) || (state == ST_XFER);
        busy         = (state != ST_IDLE);
    end

    // Next-state and completion decode.
    always_comb begin
        state_nx = state;
        finish   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (cnt_zero) begin
                        finish = 1'b1;
                    end else if (start_steal) begin
                        state_nx = ST_WAIT_EOI;
                    end else begin
                        state_nx = ST_REQ;
                    end
                end
            end
            ST_WAIT_EOI: begin
                if (end_of_instr) state_nx = ST_REQ;
            end
            ST_REQ: begin
                if (bg) state_nx = ST_XFER;
            end
            ST_XFER: begin
                if (step && (steal || cnt_one)) state_nx = ST_RELEASE;
            end
            default: begin
                if (!bg) begin
                    if (cnt_zero) begin
                        finish   = 1'b1;
                        state_nx = ST_IDLE;
                    end else begin
                        state_nx = ST_WAIT_EOI;
                    end
                end
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // One-word holding buffer toward the device in memory-to-device direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_full     <= 1'b0;
            dev_out_data <= '0;
        end else if (mem_re && mem_ack) begin
            out_full     <= 1'b1;
            dev_out_data <= mem_rdata;
        end else if (out_full && dev_out_ready) begin
            out_full     <= 1'b0;
        end
    end

    assign dev_out_valid = out_full;

    // R2: nothing is driven on the bus without the grant.
    a_r2_no_drive_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re || bus_oe) |-> (bg && br));

    // R6: a stolen cycle gives the bus back right after its word.
    a_r6_one_word_per_tenure: assert property (@(posedge clk) disable iff (!rst_n)
        (step && steal) |=> !br);

    // R9: an empty block finishes without asking for the bus.
    a_r9_empty_no_request: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && cnt_zero) |=> (!br && !busy));

    // R7: completion is only flagged once the grant is low.
    a_r7_finish_bus_free: assert property (@(posedge clk) disable iff (!rst_n)
        finish |-> (!bg && !br));
endmodule

// File: rtl/dma_ctrl.sv
// Module dma_ctrl: top of the block transfer engine. It ties the register
// window, the address/count sequencer and the bus state machine together.
// Assumes AW and CW do not exceed DW and DW is wider than 3 bits.
module dma_ctrl #(
    parameter int DW = 32,
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    reg_addr,
    input  logic          reg_wr_en,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq,
    output logic          br,
    input  logic          bg,
    input  logic          end_of_instr,
    output logic          bus_oe,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic          mem_re,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    input  logic          dev_in_valid,
    output logic          dev_in_ready,
    input  logic [DW-1:0] dev_in_data,
    output logic          dev_out_valid,
    input  logic          dev_out_ready,
    output logic [DW-1:0] dev_out_data
);
    logic          busy, finish, step;
    logic          ld_addr, ld_count, start, start_steal;
    logic          steal_q, dir_rd_q, done;
    logic          cnt_zero, cnt_one;
    logic [AW-1:0] cur_addr;
    logic [CW-1:0] cur_count;

    dma_regs #(.DW(DW), .AW(AW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .busy(busy), .finish(finish),
        .cur_addr(cur_addr), .cur_count(cur_count),
        .ld_addr(ld_addr), .ld_count(ld_count), .start(start),
        .start_steal(start_steal), .steal_q(steal_q), .dir_rd_q(dir_rd_q),
        .done(done)
    );

    dma_addr_cnt #(.AW(AW), .CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .ld_addr(ld_addr), .ld_count(ld_count),
        .new_addr(reg_wdata[AW-1:0]), .new_count(reg_wdata[CW-1:0]),
        .step(step), .addr(cur_addr), .count(cur_count),
        .cnt_zero(cnt_zero), .cnt_one(cnt_one)
    );

    dma_bus_fsm #(.DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start(start), .start_steal(start_steal), .steal(steal_q),
        .dir_rd(dir_rd_q), .cnt_zero(cnt_zero), .cnt_one(cnt_one),
        .bg(bg), .end_of_instr(end_of_instr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .dev_in_valid(dev_in_valid),
        .dev_in_data(dev_in_data), .dev_out_ready(dev_out_ready),
        .br(br), .bus_oe(bus_oe), .mem_we(mem_we), .mem_re(mem_re),
        .mem_wdata(mem_wdata), .dev_in_ready(dev_in_ready),
        .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data),
        .step(step), .finish(finish), .busy(busy)
    );

    assign mem_addr = cur_addr;
    assign irq      = done;

    // R7: the interrupt only rises with the bus already handed back.
    a_r7_irq_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (!bg && !br));
endmodule

// File: tb/tb_dma_ctrl.sv
module tb_dma_ctrl;
    localparam int DW = 32;
    localparam int AW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic          reg_wr_en = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          irq, br, bus_oe, mem_we, mem_re;
    logic          bg = 1'b0;
    logic          end_of_instr = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_ack = 1'b0;
    logic          dev_in_valid = 1'b0;
    logic          dev_in_ready;
    logic [DW-1:0] dev_in_data = '0;
    logic          dev_out_valid;
    logic          dev_out_ready = 1'b0;
    logic [DW-1:0] dev_out_data;

    dma_ctrl #(.DW(DW), .AW(AW), .CW(CW)) dut (.*);

    always #5 clk = ~clk;

    // Bench state: counters, memory image and reference-model bookkeeping.
    int checks = 0;
    int failures = 0;
    bit finished = 0;
    logic [DW-1:0] mem [0:63];
    logic [DW-1:0] exp_out [$];
    int  cyc = 0;
    int  exp_addr = 0;
    logic [DW-1:0] src_base = '0;
    int  src_idx = 0;
    int  sink_got = 0;
    int  tenures = 0;
    int  words_tenure = 0;
    int  br_rises = 0;
    bit  job_steal = 0;
    bit  hold_bg = 0;
    bit  eoi_flag = 0;
    bit  br_q = 0;
    bit  irq_q = 0;
    bit  br_d1 = 0;
    bit  src_en = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Environment and reference model, evaluated once per cycle at the falling edge.
    always @(negedge clk) begin
        bit bg_new;
        cyc++;
        if (rst_n) begin
            chk(!((bus_oe || mem_we || mem_re) && !bg), "R2 bus driven without grant",
                {bus_oe, mem_we, mem_re}, 0);
            if (irq && !irq_q) chk(!bg && !br, "R7 irq rose while bus held", bg, 0);
            if (br && !br_q) begin
                br_rises++;
                if (job_steal) begin
                    chk(eoi_flag, "R6 request without end-of-instruction", eoi_flag, 1);
                    eoi_flag = 0;
                end
            end
            // memory responder and transfer comparison
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if ((mem_we || mem_re) && bg) begin
                chk(mem_addr == AW'(exp_addr), "R3 memory cycle address", mem_addr, exp_addr);
                if (mem_we) begin
                    chk(mem_wdata == src_base + DW'(src_idx), "R4 write data order",
                        mem_wdata, src_base + DW'(src_idx));
                    mem[mem_addr[5:0]] = mem_wdata;
                    src_idx++;
                end else begin
                    mem_rdata = mem[mem_addr[5:0]];
                    exp_out.push_back(mem[mem_addr[5:0]]);
                end
                mem_ack = 1'b1;
                exp_addr++;
                words_tenure++;
                if (job_steal) chk(words_tenure <= 1, "R6 words in one tenure", words_tenure, 1);
            end
            // device sink with back-pressure
            dev_out_ready = (cyc % 3) != 1;
            if (dev_out_valid && dev_out_ready) begin
                if (exp_out.size() > 0) begin
                    chk(dev_out_data == exp_out[0], "R4 read data order", dev_out_data, exp_out[0]);
                    void'(exp_out.pop_front());
                end else begin
                    chk(0, "R4 unexpected device word", dev_out_data, 0);
                end
                sink_got++;
            end
        end
        // device source: valid is only withdrawn when no memory cycle is pending
        if (!mem_ack) dev_in_valid = src_en && ((cyc % 4) != 3);
        dev_in_data = src_base + DW'(src_idx);
        // processor end-of-instruction pulses
        end_of_instr = (cyc % 7) == 0;
        if (end_of_instr) eoi_flag = 1;
        // arbiter: grant follows request one cycle later, optionally held
        bg_new = (hold_bg && bg) ? 1'b1 : br_d1;
        br_d1 = br;
        if (bg_new && !bg) begin
            tenures++;
            words_tenure = 0;
        end
        bg = bg_new;
        br_q = br;
        irq_q = irq;
    end

    task automatic reg_write(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic start_job(input int a, input int n, input bit steal, input bit rd,
                             input logic [DW-1:0] base);
        src_base = base; src_idx = 0; exp_addr = a; tenures = 0; sink_got = 0;
        job_steal = steal; src_en = !rd;
        reg_write(2'd0, DW'(a));
        reg_write(2'd1, DW'(n));
        reg_write(2'd2, {29'd0, rd, steal, 1'b1});
    endtask

    task automatic wait_irq(input string tag);
        int n = 0;
        while (!irq && n < 3000) begin @(negedge clk); n++; end
        chk(irq, tag, irq, 1);
    endtask

    task automatic wait_sink(input int want);
        int n = 0;
        while (sink_got < want && n < 3000) begin @(negedge clk); n++; end
        chk(sink_got == want, "R4 words delivered to device", sink_got, want);
    endtask

    initial begin
        logic [DW-1:0] v;
        int rises_before;
        for (int i = 0; i < 64; i++) mem[i] = DW'(32'h5500_0000 + i * 7);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        for (int a = 0; a < 4; a++) begin
            reg_read(2'(a), v);
            chk(v == '0, "R1 reset value of register", v, 0);
        end
        chk(!br && !irq, "R1 no request or interrupt after reset", {br, irq}, 0);

        // T1: continuous, device to memory
        start_job(8, 5, 0, 0, 32'hA100_0000);
        wait_irq("R7 done after continuous write block");
        for (int i = 0; i < 5; i++)
            chk(mem[8 + i] == 32'hA100_0000 + DW'(i), "R4 memory image after write block",
                mem[8 + i], 32'hA100_0000 + i);
        chk(tenures == 1, "R5 one tenure for continuous block", tenures, 1);
        reg_read(2'd0, v); chk(v == 13, "R3 address after block", v, 13);
        reg_read(2'd1, v); chk(v == 0, "R3 count after block", v, 0);
        reg_read(2'd3, v); chk(v == 2, "R7 status busy clear and done set", v, 2);
        reg_read(2'd2, v); chk(v == 0, "R1 control readback", v, 0);
        reg_write(2'd3, 32'h2);
        #1 chk(!irq, "R8 done cleared by status write", irq, 0);

        // T2: stealing, memory to device, with ignored writes while busy
        start_job(32, 4, 1, 1, '0);
        reg_write(2'd1, 32'd99);
        reg_write(2'd0, 32'd5);
        reg_write(2'd2, 32'h1);
        reg_read(2'd1, v); chk(v <= 4, "R10 count write ignored while busy", v, 4);
        reg_read(2'd2, v); chk(v == 6, "R10 control write ignored while busy", v, 6);
        reg_read(2'd3, v); chk(v[0] == 1'b1, "R1 busy flag during block", v[0], 1);
        wait_irq("R7 done after stealing block");
        wait_sink(4);
        chk(tenures == 4, "R6 one tenure per word", tenures, 4);
        reg_read(2'd0, v); chk(v == 36, "R10 address write ignored while busy", v, 36);
        reg_write(2'd3, 32'h2);

        // T3: empty block
        rises_before = br_rises;
        reg_write(2'd1, 32'd0);
        job_steal = 0;
        reg_write(2'd2, 32'h1);
        #1 chk(irq, "R9 done right after empty start", irq, 1);
        reg_read(2'd3, v); chk(v == 2, "R9 status after empty start", v, 2);
        repeat (5) @(negedge clk);
        chk(br_rises == rises_before, "R9 no request for empty block", br_rises - rises_before, 0);

        // T4: completion and clear in the same cycle; done is still set from T3
        @(posedge clk); #1 hold_bg = 1;
        start_job(48, 2, 0, 0, 32'hC300_0000);
        while (br || !bg) @(posedge clk);
        #1 hold_bg = 0;
        @(negedge clk);
        reg_addr = 2'd3; reg_wdata = 32'h2; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
        #1 chk(irq, "R8 completion wins over same-cycle clear", irq, 1);
        reg_read(2'd1, v); chk(v == 0, "R3 count after held-grant block", v, 0);
        reg_write(2'd3, 32'h2);
        #1 chk(!irq, "R8 later clear takes effect", irq, 0);

        // T5: continuous, memory to device with back-pressure
        start_job(20, 3, 0, 1, '0);
        wait_irq("R7 done after continuous read block");
        wait_sink(3);
        chk(tenures == 1, "R5 one tenure for continuous read", tenures, 1);
        reg_read(2'd0, v); chk(v == 23, "R3 address after read block", v, 23);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1500000;
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule